// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is a per-processor interval timer. Software programs it through a four-register port. A timer entry holds an 8-bit interrupt vector, a mask bit and a mode bit that selects periodic or one-shot operation. A divide register picks the prescale applied to the bus clock. An initial-count register loads and starts a 32-bit down-counter, and a read-only register shows the live counter value.

Each divided clock tick takes one from the counter. The tick that would bring the counter to zero is the terminal tick. On that tick the block emits a one-cycle interrupt request carrying the programmed vector, unless the entry is masked. After the terminal tick the counter either reloads from the initial count (periodic) or stops at zero (one-shot). The interrupt request goes to an interrupt controller that lies outside this block.

Top module: `lt_timer`

## Requirements
- R1: After reset the timer entry reads vector 0, mask set and one-shot mode. The divide code, initial count and current count read 0, and irq_valid and irq_vector are 0.
- R2: Reads are combinational on reg_rdata for the selected reg_addr. Address 0 is the timer entry: bits [7:0] vector, bit 8 mask, bit 9 periodic, and all other bits read 0. Address 1 holds the divide code in bits [2:0]. Address 2 is the initial count (read/write). Address 3 is the current count, and writes to it are ignored.
- R3: A write of N to address 2 loads the counter with N in that clock edge and zeroes the prescaler phase. While the counter is non-zero it then drops by one every 2^code clocks.
- R4: The divisor is 2^code for code 0..7, which is divide-by-1 up to divide-by-128 (code 4 is divide-by-16). A write to address 1 zeroes the prescaler phase, and no tick happens in that cycle.
- R5: In one-shot mode (bit 9 = 0), the single interrupt pulse is visible N*2^code clocks after the initial-count write edge. The counter then stays at 0 until address 2 is written again.
- R6: In periodic mode (bit 9 = 1), the counter reloads the initial count on each terminal tick. Pulses repeat every N*2^code clocks.
- R7: While the mask bit is set, no pulse is produced but counting goes on. The mask value held before the terminal-tick edge is the one that applies.
- R8: irq_valid is high for exactly the one cycle after a terminal-tick edge. In that cycle irq_vector equals the programmed vector, and it holds that value until the next terminal tick.
- R9: A write of 0 to address 2 stops the timer, with the count at 0 and no pulse.
- R10: When an initial-count write falls in the same cycle as a terminal tick, the write wins. No pulse is produced and the counter loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the latest request |

## Verification
Two functions can land in the same cycle. A software reload of the initial count can meet the terminal tick of the running count, and a mask write can meet a terminal tick. The bench provokes the first with a divide-by-1 one-shot run of 3, then rewrites the initial count so that the write is sampled on the third edge. It judges the result by the absence of any pulse at that edge and a single pulse exactly seven clocks later. The behavioural model runs alongside on every clock, so mask, divide and count writes that land in any cycle are compared too.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ENTRY = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_INIT  = 2'd2,
    SEL_COUNT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/lt_regs.sv
module lt_regs
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [VEC_W-1:0]  vec,
  output logic              mask,
  output logic              periodic,
  output logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  init,
  output logic              load,
  output logic              div_wr,
  output logic [CNT_W-1:0]  rdata
);
  reg_sel_e          sel;
  logic              entry_wr;
  logic              init_wr;
  logic [VEC_W-1:0]  vec_d;
  logic              mask_d;
  logic              per_d;
  logic [CODE_W-1:0] code_d;
  logic [CNT_W-1:0]  init_d;

  assign sel      = reg_sel_e'(addr);
  assign entry_wr = wr_en && (sel == SEL_ENTRY);
  assign div_wr   = wr_en && (sel == SEL_DIV);
  assign init_wr  = wr_en && (sel == SEL_INIT);
  assign load     = init_wr;

  always_comb begin
    vec_d  = vec;
    mask_d = mask;
    per_d  = periodic;
    code_d = code;
    init_d = init;
    if (entry_wr) begin
      vec_d  = wdata[VEC_W-1:0];
      mask_d = wdata[VEC_W];
      per_d  = wdata[VEC_W+1];
    end
    if (div_wr) code_d = wdata[CODE_W-1:0];
    if (init_wr) init_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec      <= '0;
      mask     <= 1'b1;
      periodic <= 1'b0;
      code     <= '0;
      init     <= '0;
    end else begin
      vec      <= vec_d;
      mask     <= mask_d;
      periodic <= per_d;
      code     <= code_d;
      init     <= init_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_ENTRY: begin
        rdata[VEC_W-1:0] = vec;
        rdata[VEC_W]     = mask;
        rdata[VEC_W+1]   = periodic;
      end
      SEL_DIV:   rdata[CODE_W-1:0] = code;
      SEL_INIT:  rdata = init;
      SEL_COUNT: rdata = count;
      default:   rdata = '0;
    endcase
  end

  AST_COUNT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_COUNT) |=> $stable(init) && $stable(vec) && $stable(code)) // R2
    else $error("count write touched a register");
endmodule

// File: rtl/lt_prescale.sv
module lt_prescale #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int PRE_W = (1 << CODE_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] lim;

  assign lim  = ~({PRE_W{1'b1}} << code);
  assign tick = run && !clr && (pre_q == lim);

  always_comb begin
    if (clr || !run || tick) pre_d = '0;
    else                     pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= lim) // R4
    else $error("prescaler past its limit");
endmodule

// File: rtl/lt_count.sv
module lt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             last;

  assign run  = (cnt != '0);
  assign last = (cnt == ONE);
  assign fire = tick && last && !load;

  always_comb begin
    cnt_d = cnt;
    if (load)           cnt_d = load_val;
    else if (fire)      cnt_d = periodic ? reload : '0;
    else if (tick)      cnt_d = cnt - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> cnt == '0) // R5
    else $error("stopped counter moved");
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt > ONE && !load) |=> cnt == $past(cnt) - ONE) // R3
    else $error("bad decrement");
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && periodic) |=> cnt == $past(reload)) // R6
    else $error("bad periodic reload");
endmodule

// File: rtl/lt_timer.sv
module lt_timer
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [VEC_W-1:0]  vec;
  logic              mask;
  logic              periodic;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  init;
  logic              load;
  logic              div_wr;
  logic [CNT_W-1:0]  cnt;
  logic              run;
  logic              tick;
  logic              fire;
  logic              irq_d;
  logic [VEC_W-1:0]  ivec_d;

  lt_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .count(cnt), .vec(vec), .mask(mask),
    .periodic(periodic), .code(code), .init(init), .load(load),
    .div_wr(div_wr), .rdata(reg_rdata)
  );

  lt_prescale #(.CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(load || div_wr),
    .code(code), .tick(tick)
  );

  lt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(reg_wdata),
    .reload(init), .periodic(periodic), .tick(tick), .cnt(cnt),
    .run(run), .fire(fire)
  );

  always_comb begin
    irq_d  = fire && !mask;
    ivec_d = fire ? vec : irq_vector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= irq_d;
      irq_vector <= ivec_d;
    end
  end

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask)) // R7
    else $error("pulse while masked");
  AST_ZERO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SEL_INIT && reg_wdata == '0) |=> (!irq_valid && cnt == '0)) // R9
    else $error("zero write did not stop");
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!irq_valid && cnt == $past(reg_wdata))) // R10
    else $error("load lost to terminal tick");
  AST_VEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector == $past(vec)) // R8
    else $error("vector mismatch");
endmodule

// File: tb/sim_lt_timer.sv
module sim_lt_timer;
  localparam int CLK_T = 10;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int checks;
  int errors;
  int cyc;
  int pulses[$];

  // behavioural reference state
  int unsigned m_vec, m_mask, m_per, m_code, m_init, m_cnt, m_pre, m_irq, m_vo;

  lt_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vec = 0; m_mask = 1; m_per = 0; m_code = 0; m_init = 0;
      m_cnt = 0; m_pre = 0; m_irq = 0; m_vo = 0;
    end else begin
      bit ld, dw, tk, fr;
      int unsigned npre, ncnt;
      ld = reg_wr && reg_addr == 2;
      dw = reg_wr && reg_addr == 1;
      tk = 0; fr = 0;
      if (ld || dw || m_cnt == 0) npre = 0;
      else if (m_pre == (1 << m_code) - 1) begin tk = 1; npre = 0; end
      else npre = m_pre + 1;
      if (ld) ncnt = reg_wdata;
      else if (tk && m_cnt == 1) begin fr = 1; ncnt = m_per ? m_init : 0; end
      else if (tk) ncnt = m_cnt - 1;
      else ncnt = m_cnt;
      m_irq = (fr && m_mask == 0) ? 1 : 0;
      if (fr) m_vo = m_vec;
      m_pre = npre;
      m_cnt = ncnt;
      if (reg_wr && reg_addr == 0) begin
        m_vec = reg_wdata[7:0]; m_mask = reg_wdata[8]; m_per = reg_wdata[9];
      end
      if (dw) m_code = reg_wdata[2:0];
      if (ld) m_init = reg_wdata;
    end
  end

  function automatic int unsigned model_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_vec | (m_mask << 8) | (m_per << 9);
      2'd1:    return m_code;
      2'd2:    return m_init;
      default: return m_cnt;
    endcase
  endfunction

  always @(posedge clk) begin
    #(CLK_T/4);
    cyc++;
    if (rst_n) begin
      chk("R8 irq_valid vs model", irq_valid, m_irq);
      chk("R8 irq_vector vs model", irq_vector, m_vo);
      chk("R2 reg_rdata vs model", reg_rdata, model_read(reg_addr));
      if (irq_valid) pulses.push_back(cyc);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int wc);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    wc = cyc + 1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w, k;
    logic [31:0] v, v2;
    checks = 0; errors = 0; cyc = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, v); chk("R1 entry after reset", v, 32'h100);
    rd(1, v); chk("R1 divide after reset", v, 0);
    rd(2, v); chk("R1 initial after reset", v, 0);
    rd(3, v); chk("R1 count after reset", v, 0);
    chk("R1 irq_valid after reset", irq_valid, 0);
    chk("R1 irq_vector after reset", irq_vector, 0);

    // R2 reserved entry bits, read-only count
    wr(0, 32'hFFFF_FFFF, w);
    rd(0, v); chk("R2 entry reserved bits", v, 32'h3FF);
    wr(3, 32'h1234, w);
    rd(3, v); chk("R2 count write ignored", v, 0);
    rd(2, v); chk("R2 count write leaves initial", v, 0);

    // R5 R8 one-shot, divide by 1
    wr(0, 32'h042, w);
    wr(1, 0, w);
    pulses.delete();
    wr(2, 5, w);
    idle(20);
    chk("R5 one-shot pulse count", pulses.size(), 1);
    if (pulses.size() > 0) chk("R5 one-shot pulse time", pulses[0], w + 5);
    chk("R8 vector held", irq_vector, 8'h42);
    rd(3, v); chk("R5 counter parked at zero", v, 0);

    // R3 decrement rate with divide by 2
    wr(1, 1, w);
    wr(2, 100, w);
    rd(3, v); chk("R3 load value", v, 100);
    idle(6);
    rd(3, v); chk("R3 count after 6 clocks div2", v, 97);
    wr(2, 0, w);

    // R6 R4 periodic, divide by 4
    wr(0, 32'h2A5, w);
    wr(1, 2, w);
    pulses.delete();
    wr(2, 4, w);
    idle(52);
    chk("R6 periodic pulse count", pulses.size(), 3);
    if (pulses.size() == 3) begin
      chk("R4 first pulse at N*4", pulses[0], w + 16);
      chk("R6 interval 1", pulses[1] - pulses[0], 16);
      chk("R6 interval 2", pulses[2] - pulses[1], 16);
    end
    chk("R8 periodic vector", irq_vector, 8'hA5);

    // R4 divide by 16 timing
    wr(1, 4, w);
    pulses.delete();
    wr(2, 3, w);
    idle(100);
    chk("R4 div16 pulse count", pulses.size(), 2);
    if (pulses.size() == 2) begin
      chk("R4 div16 first pulse", pulses[0], w + 48);
      chk("R4 div16 interval", pulses[1] - pulses[0], 48);
    end

    // R7 masked periodic keeps counting
    wr(0, 32'h3A5, w);
    wr(1, 0, w);
    wr(2, 9, w);
    pulses.delete();
    rd(3, v);
    idle(3);
    rd(3, v2);
    chk("R7 masked counter runs", (v != v2), 1);
    idle(40);
    chk("R7 no pulse while masked", pulses.size(), 0);

    // R9 zero write stops an unmasked periodic timer
    wr(0, 32'h2A5, w);
    wr(2, 0, w);
    pulses.delete();
    idle(40);
    chk("R9 no pulse after zero write", pulses.size(), 0);
    rd(3, v); chk("R9 count stopped", v, 0);

    // R10 initial write in the terminal-tick cycle
    wr(0, 32'h042, w);
    pulses.delete();
    wr(2, 3, k);
    idle(2);
    wr(2, 7, w);
    chk("R10 write sampled on terminal edge", w, k + 3);
    idle(20);
    chk("R10 single pulse", pulses.size(), 1);
    if (pulses.size() > 0) chk("R10 pulse from new load", pulses[0], k + 10);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule